// File: doc/BRIEF.md
# Byte-Granular Direct-Mapped Cache Controller

The block sits between a CPU with a 24-bit address and a slower main-memory bus. The address splits into an 8-bit bank and a 16-bit in-bank offset. Each cache line is one byte. Per index the controller keeps three things: the data byte, a tag byte that records the bank the byte came from, and a narrow side array. The side array holds the offset bits above the index. A location is empty when its tag holds the reserved bank value 8'hEF. No separate valid bit exists.

The controller clock runs at four times the CPU cycle rate, so every CPU cycle has four phases, numbered 0 to 3. The CPU marks a valid address with a qualifier, which the controller samples only in phase 1. In the same clock the tag and data arrays are read with the index. The tag result is compared in phase 2, and the decision takes effect in phase 3. A read hit is returned in phase 3 and uses no main-bus traffic.

Misses and all writes stall the CPU and run a request/acknowledge transfer on the main bus. A read miss fills the line. A write that hits updates the cached byte, and a write that misses leaves the cache unchanged. A flush input walks every index, one per clock, and marks each one empty while the CPU is held.

Top module: `bytecache_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it, every output is 0. After reset every location is empty, so the first read of any address misses.
- R2: The phase count is 0 after reset and advances by one per clock in phase order 0,1,2,3. The address qualifier is acted on only when it is high in phase 1 while the controller is idle. When it is high at any other time it has no effect on any output.
- R3: A read hit raises `cpu_done` for one clock, with `cpu_rdata` equal to the cached byte. This happens two clocks after the qualifier was sampled, which is phase 3. There is no stall and no `mem_req`.
- R4: A read miss raises `cpu_stall` in the decision clock. From the next clock `mem_req` is held with `mem_we`=0 and the full request address until `mem_ack` is seen. In the acknowledge clock `cpu_done` is 1 and `cpu_rdata` equals `mem_rdata`. In the following clock `cpu_stall` is 0 and the phase count is 0.
- R5: After a read miss, the byte returned from main memory is stored. A later read of the same address hits and returns that byte.
- R6: A hit needs both fields to match: the stored bank must equal address bits 23:16, and the stored upper offset must equal bits 15:6. The index is bits 5:0. An address that shares the index but differs in either field misses, and its fill replaces the previous line.
- R7: Addresses in bank 8'hEF never hit, even right after they were fetched.
- R8: Every write runs on the main bus with `mem_we`=1, the request address and `mem_wdata`. It stalls until acknowledged and raises `cpu_done` in the acknowledge clock with `cpu_rdata`=0. A write that hits replaces the cached byte. A write that misses allocates nothing, so a later read of that address misses.
- R9: A flush seen while idle takes priority over the address qualifier in the same clock. It stalls the CPU for exactly 64 clocks, one per index, and afterwards every location is empty.
- R10: Whenever `mem_req` is 0, `mem_we`, `mem_addr` and `mem_wdata` are 0. Whenever `cpu_done` is 0, `cpu_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, four per CPU cycle |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | CPU address qualifier |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | 24 | CPU address: bank in 23:16, offset in 15:0 |
| cpu_wdata | input | 8 | CPU write byte |
| flush | input | 1 | Invalidate the whole cache |
| cpu_stall | output | 1 | Hold the CPU |
| cpu_done | output | 1 | Access completes this clock |
| cpu_rdata | output | 8 | Read byte, valid with cpu_done |
| mem_req | output | 1 | Main-bus request, held until acknowledged |
| mem_we | output | 1 | Main-bus access is a write |
| mem_addr | output | 24 | Main-bus address |
| mem_wdata | output | 8 | Main-bus write byte |
| mem_ack | input | 1 | Main-bus acknowledge |
| mem_rdata | input | 8 | Main-bus read byte, valid with mem_ack |

## Verification
A wrong tag or side-array entry changes whether the next access to that index hits. A missed hit shows as an unexpected stall and bus request in phase 3 of that access. A false hit shows as a done pulse carrying a stale byte. A corrupt data byte shows only in the `cpu_rdata` of a later hit on that line, so the sequence rereads every line it has filled or written. A slipped phase count moves the sampling of the qualifier, and a reference model that runs in lock step exposes it within one CPU cycle.

// File: rtl/bcache_pkg.sv
package bcache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_DECIDE,
        ST_BUS,
        ST_FLUSH
    } seq_state_e;

    typedef logic [1:0] phase_t;

    localparam phase_t PH_SAMPLE = 2'd1;
    localparam phase_t PH_FIRST  = 2'd0;

    typedef struct packed {
        logic stall;
        logic done;
        logic bus_req;
        logic bus_write;
    } seq_flags_t;

    function automatic phase_t next_phase(input phase_t cur);
        return phase_t'(cur + 2'd1);
    endfunction

endpackage

// File: rtl/bcache_phase.sv
module bcache_phase
    import bcache_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   hold,
    input  logic   restart,
    output phase_t ph
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= PH_FIRST;
        end else if (restart) begin
            ph <= PH_FIRST;
        end else if (!hold) begin
            ph <= next_phase(ph);
        end
    end

endmodule

// File: rtl/bcache_tags.sv
module bcache_tags #(
    parameter int BANK_W = 8,
    parameter int UP_W   = 10,
    parameter int IDX_W  = 6,
    parameter logic [BANK_W-1:0] INV_BANK = 8'hEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [BANK_W-1:0] cmp_bank,
    input  logic [UP_W-1:0]   cmp_up,
    output logic              hit,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [UP_W-1:0]   wr_up
);

    localparam int DEPTH = 1 << IDX_W;

    logic [BANK_W-1:0] bank_mem [DEPTH];
    logic [UP_W-1:0]   up_mem   [DEPTH];
    logic [BANK_W-1:0] bank_q;
    logic [UP_W-1:0]   up_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                bank_mem[i] <= INV_BANK;
                up_mem[i]   <= '0;
            end
            bank_q <= INV_BANK;
            up_q   <= '0;
        end else begin
            if (wr_en) begin
                bank_mem[wr_idx] <= wr_bank;
                up_mem[wr_idx]   <= wr_up;
            end
            if (rd_en) begin
                bank_q <= bank_mem[rd_idx];
                up_q   <= up_mem[rd_idx];
            end
        end
    end

    always_comb begin
        hit = (bank_q == cmp_bank) && (up_q == cmp_up) && (cmp_bank != INV_BANK);
    end

endmodule

// File: rtl/bcache_data.sv
module bcache_data #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_q,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_val
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= mem[rd_idx];
        end
    end

endmodule

// File: rtl/bcache_seq.sv
module bcache_seq
    import bcache_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_t            ph,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              flush,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              hit,
    input  logic [DATA_W-1:0] data_q,
    output logic              cpu_stall,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              ph_hold,
    output logic              ph_restart,
    output logic              lookup,
    output logic [ADDR_W-1:0] req_addr,
    output logic              data_wr_en,
    output logic [IDX_W-1:0]  data_wr_idx,
    output logic [DATA_W-1:0] data_wr_val,
    output logic              tag_wr_en,
    output logic              tag_wr_inval,
    output logic [IDX_W-1:0]  tag_wr_idx
);

    seq_state_e        state, state_n;
    logic              req_we;
    logic [DATA_W-1:0] req_wd;
    logic              hit_q;
    logic [IDX_W-1:0]  walk;
    logic              walk_last;
    logic              read_hit;
    logic              bus_fin;
    logic [IDX_W-1:0]  req_idx;
    seq_flags_t        flags;

    assign req_idx   = req_addr[IDX_W-1:0];
    assign walk_last = (walk == {IDX_W{1'b1}});
    assign lookup    = (state == ST_IDLE) && !flush && cpu_valid && (ph == PH_SAMPLE);
    assign read_hit  = (state == ST_DECIDE) && hit_q && !req_we;
    assign bus_fin   = (state == ST_BUS) && mem_ack;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (flush) begin
                    state_n = ST_FLUSH;
                end else if (lookup) begin
                    state_n = ST_LOOK;
                end
            end
            ST_LOOK:   state_n = ST_DECIDE;
            ST_DECIDE: state_n = read_hit ? ST_IDLE : ST_BUS;
            ST_BUS:    state_n = mem_ack ? ST_IDLE : ST_BUS;
            ST_FLUSH:  state_n = walk_last ? ST_IDLE : ST_FLUSH;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            req_addr <= '0;
            req_we   <= 1'b0;
            req_wd   <= '0;
            hit_q    <= 1'b0;
            walk     <= '0;
        end else begin
            state <= state_n;
            if (lookup) begin
                req_addr <= cpu_addr;
                req_we   <= cpu_we;
                req_wd   <= cpu_wdata;
            end
            if (state == ST_LOOK) begin
                hit_q <= hit;
            end
            if (state == ST_IDLE) begin
                walk <= '0;
            end else if (state == ST_FLUSH) begin
                walk <= walk + 1'b1;
            end
        end
    end

    always_comb begin
        flags.stall     = ((state == ST_DECIDE) && !read_hit) ||
                          (state == ST_BUS) || (state == ST_FLUSH);
        flags.done      = read_hit || bus_fin;
        flags.bus_req   = (state == ST_BUS);
        flags.bus_write = (state == ST_BUS) && req_we;
    end

    assign cpu_stall = flags.stall;
    assign cpu_done  = flags.done;
    assign mem_req   = flags.bus_req;
    assign mem_we    = flags.bus_write;
    assign mem_addr  = flags.bus_req ? req_addr : '0;
    assign mem_wdata = flags.bus_write ? req_wd : '0;

    always_comb begin
        if (read_hit) begin
            cpu_rdata = data_q;
        end else if (bus_fin && !req_we) begin
            cpu_rdata = mem_rdata;
        end else begin
            cpu_rdata = '0;
        end
    end

    assign ph_hold    = (state == ST_BUS) || (state == ST_FLUSH);
    assign ph_restart = bus_fin || ((state == ST_FLUSH) && walk_last);

    assign data_wr_en  = ((state == ST_DECIDE) && req_we && hit_q) || (bus_fin && !req_we);
    assign data_wr_idx = req_idx;
    assign data_wr_val = req_we ? req_wd : mem_rdata;

    assign tag_wr_en    = (bus_fin && !req_we) || (state == ST_FLUSH);
    assign tag_wr_inval = (state == ST_FLUSH);
    assign tag_wr_idx   = (state == ST_FLUSH) ? walk : req_idx;

endmodule

// File: rtl/bytecache_ctrl.sv
module bytecache_ctrl
    import bcache_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int OFF_W  = 16,
    parameter int IDX_W  = 6,
    parameter int DATA_W = 8,
    parameter logic [BANK_W-1:0] INV_BANK = 8'hEF
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cpu_valid,
    input  logic                      cpu_we,
    input  logic [BANK_W+OFF_W-1:0]   cpu_addr,
    input  logic [DATA_W-1:0]         cpu_wdata,
    input  logic                      flush,
    output logic                      cpu_stall,
    output logic                      cpu_done,
    output logic [DATA_W-1:0]         cpu_rdata,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [BANK_W+OFF_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]         mem_wdata,
    input  logic                      mem_ack,
    input  logic [DATA_W-1:0]         mem_rdata
);

    localparam int ADDR_W = BANK_W + OFF_W;
    localparam int UP_W   = OFF_W - IDX_W;

    phase_t            ph;
    logic              ph_hold;
    logic              ph_restart;
    logic              lookup;
    logic [ADDR_W-1:0] req_addr;
    logic              hit;
    logic [DATA_W-1:0] data_q;
    logic              data_wr_en;
    logic [IDX_W-1:0]  data_wr_idx;
    logic [DATA_W-1:0] data_wr_val;
    logic              tag_wr_en;
    logic              tag_wr_inval;
    logic [IDX_W-1:0]  tag_wr_idx;
    logic [BANK_W-1:0] tag_wr_bank;
    logic [UP_W-1:0]   tag_wr_up;

    assign tag_wr_bank = tag_wr_inval ? INV_BANK : req_addr[ADDR_W-1:OFF_W];
    assign tag_wr_up   = tag_wr_inval ? '0 : req_addr[OFF_W-1:IDX_W];

    bcache_phase u_phase (
        .clk     (clk),
        .rst     (rst),
        .hold    (ph_hold),
        .restart (ph_restart),
        .ph      (ph)
    );

    bcache_tags #(
        .BANK_W   (BANK_W),
        .UP_W     (UP_W),
        .IDX_W    (IDX_W),
        .INV_BANK (INV_BANK)
    ) u_tags (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (lookup),
        .rd_idx   (cpu_addr[IDX_W-1:0]),
        .cmp_bank (req_addr[ADDR_W-1:OFF_W]),
        .cmp_up   (req_addr[OFF_W-1:IDX_W]),
        .hit      (hit),
        .wr_en    (tag_wr_en),
        .wr_idx   (tag_wr_idx),
        .wr_bank  (tag_wr_bank),
        .wr_up    (tag_wr_up)
    );

    bcache_data #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_data (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (lookup),
        .rd_idx (cpu_addr[IDX_W-1:0]),
        .rd_q   (data_q),
        .wr_en  (data_wr_en),
        .wr_idx (data_wr_idx),
        .wr_val (data_wr_val)
    );

    bcache_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .ph           (ph),
        .cpu_valid    (cpu_valid),
        .cpu_we       (cpu_we),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .flush        (flush),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .hit          (hit),
        .data_q       (data_q),
        .cpu_stall    (cpu_stall),
        .cpu_done     (cpu_done),
        .cpu_rdata    (cpu_rdata),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .ph_hold      (ph_hold),
        .ph_restart   (ph_restart),
        .lookup       (lookup),
        .req_addr     (req_addr),
        .data_wr_en   (data_wr_en),
        .data_wr_idx  (data_wr_idx),
        .data_wr_val  (data_wr_val),
        .tag_wr_en    (tag_wr_en),
        .tag_wr_inval (tag_wr_inval),
        .tag_wr_idx   (tag_wr_idx)
    );

endmodule

// File: rtl/bcache_checker.sv
module bcache_checker #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_stall,
    input logic              cpu_done,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack
);

    AST_REQ_STALLS: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> cpu_stall); // R4

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R4

    AST_STALL_DROPS: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> (!cpu_stall && !mem_req)); // R4

    AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        (cpu_done && !cpu_stall) |-> !mem_req); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done); // R3

    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !mem_req |-> (!mem_we && mem_addr == '0 && mem_wdata == '0)); // R10

    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cpu_done |-> (cpu_rdata == '0)); // R10

    AST_WRITE_DONE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cpu_done && mem_we) |-> (cpu_rdata == '0)); // R8

endmodule

bind bytecache_ctrl bcache_checker #(
    .ADDR_W (BANK_W + OFF_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_stall (cpu_stall),
    .cpu_done  (cpu_done),
    .cpu_rdata (cpu_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
);

// File: tb/bytecache_ctrl_test.sv
`timescale 1ns/1ps
module bytecache_ctrl_test;

    localparam int DEPTH = 64;
    localparam logic [7:0] INV = 8'hEF;
    localparam int S_IDLE = 0, S_LOOK = 1, S_DEC = 2, S_MEM = 3, S_FL = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_valid = 1'b0;
    logic        cpu_we = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        flush = 1'b0;
    logic        cpu_stall, cpu_done, mem_req, mem_we;
    logic [7:0]  cpu_rdata, mem_wdata;
    logic [23:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;

    bytecache_ctrl uut (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .flush(flush),
        .cpu_stall(cpu_stall), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #4 clk = ~clk;

    typedef struct {
        int          kind;
        logic [23:0] addr;
        logic [7:0]  wd;
        int          delay;
        string       tag;
    } op_t;

    op_t ops[$];

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit started = 1'b0;
    bit finished = 1'b0;

    int          mst = S_IDLE;
    int          mph = 0;
    int          mfcnt = 0;
    int          flcycles = 0;
    logic [23:0] m_addr = '0;
    logic        m_we = 1'b0;
    logic [7:0]  m_wd = '0;
    bit          m_hit = 1'b0;
    int          m_delay = 0;
    string       m_tag = "R10";
    logic [7:0]  mtag [DEPTH];
    logic [9:0]  mup  [DEPTH];
    logic [7:0]  mdat [DEPTH];
    logic [7:0]  mainmem [int];
    int          wcnt = 0;

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        if (mainmem.exists(int'(a))) return mainmem[int'(a)];
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, cycles, got, exp);
        end
    endtask

    task automatic add(input int k, input logic [23:0] a, input logic [7:0] d,
                       input int dl, input string t);
        op_t o;
        o.kind = k; o.addr = a; o.wd = d; o.delay = dl; o.tag = t;
        ops.push_back(o);
    endtask

    // Reference model state update, on the same edge the design uses
    always @(posedge clk) begin
        started = 1'b1;
        cycles++;
        if (rst) begin
            mst = S_IDLE; mph = 0; mfcnt = 0;
            for (int i = 0; i < DEPTH; i++) begin
                mtag[i] = INV; mup[i] = '0;
            end
        end else begin
            case (mst)
                S_IDLE: begin
                    if (flush) begin
                        mst = S_FL; mfcnt = 0; m_tag = "R9";
                        void'(ops.pop_front());
                    end else if (cpu_valid && mph == 1) begin
                        m_addr = cpu_addr; m_we = cpu_we; m_wd = cpu_wdata;
                        m_delay = ops[0].delay; m_tag = ops[0].tag;
                        void'(ops.pop_front());
                        mst = S_LOOK;
                    end
                    mph = (mph + 1) % 4;
                end
                S_LOOK: begin
                    m_hit = (mtag[m_addr[5:0]] == m_addr[23:16]) &&
                            (mup[m_addr[5:0]] == m_addr[15:6]) && (m_addr[23:16] != INV);
                    mst = S_DEC;
                    mph = (mph + 1) % 4;
                end
                S_DEC: begin
                    if (!m_we && m_hit) begin
                        mst = S_IDLE;
                    end else begin
                        if (m_we && m_hit) mdat[m_addr[5:0]] = m_wd;
                        mst = S_MEM;
                    end
                    mph = (mph + 1) % 4;
                end
                S_MEM: begin
                    if (mem_ack) begin
                        if (!m_we) begin
                            mtag[m_addr[5:0]] = m_addr[23:16];
                            mup[m_addr[5:0]]  = m_addr[15:6];
                            mdat[m_addr[5:0]] = mem_rdata;
                        end
                        mst = S_IDLE; mph = 0;
                    end
                end
                default: begin
                    mtag[mfcnt] = INV;
                    flcycles++;
                    if (mfcnt == DEPTH - 1) begin
                        mst = S_IDLE; mph = 0;
                    end else begin
                        mfcnt++;
                    end
                end
            endcase
        end
    end

    // Drive inputs at the falling edge, then compare a little later
    always @(negedge clk) begin
        logic        rh, fin, e_stall, e_done, e_req, e_we;
        logic [7:0]  e_rd, e_wd;
        logic [23:0] e_addr;
        string       tag;
        if (!rst && !finished) begin
            if (mem_ack) begin
                mem_ack = 1'b0; wcnt = 0;
            end else if (mem_req) begin
                if (wcnt >= m_delay) begin
                    mem_ack = 1'b1;
                    mem_rdata = mem_byte(mem_addr);
                    if (mem_we) mainmem[int'(mem_addr)] = mem_wdata;
                end else begin
                    wcnt++;
                end
            end
            if (mst == S_IDLE && ops.size() > 0) begin
                cpu_valid = 1'b1;
                flush     = (ops[0].kind == 2);
                cpu_addr  = ops[0].addr;
                cpu_we    = (ops[0].kind == 1);
                cpu_wdata = ops[0].wd;
            end else if (mst != S_IDLE) begin
                cpu_valid = 1'b1; flush = 1'b0; cpu_we = 1'b0;
                cpu_addr  = 24'h00_0005 ^ 24'(cycles);
                cpu_wdata = 8'hA5;
            end else begin
                cpu_valid = 1'b0; flush = 1'b0; cpu_we = 1'b0;
            end
        end
        #1;
        if (started && !finished) begin
            rh  = (mst == S_DEC) && m_hit && !m_we;
            fin = (mst == S_MEM) && mem_ack;
            e_stall = ((mst == S_DEC) && !rh) || (mst == S_MEM) || (mst == S_FL);
            e_done  = rh || fin;
            e_rd    = rh ? mdat[m_addr[5:0]] : ((fin && !m_we) ? mem_rdata : 8'h00);
            e_req   = (mst == S_MEM);
            e_we    = e_req && m_we;
            e_addr  = e_req ? m_addr : 24'h0;
            e_wd    = e_we ? m_wd : 8'h00;
            if (rst) tag = "R1";
            else if (mst == S_FL) tag = "R9";
            else if (mst == S_IDLE) tag = cpu_valid ? "R2" : "R10";
            else tag = m_tag;
            check(tag,
                  {20'h0, cpu_stall, cpu_done, cpu_rdata, mem_req, mem_we, mem_addr, mem_wdata},
                  {20'h0, e_stall, e_done, e_rd, e_req, e_we, e_addr, e_wd});
        end
    end

    initial begin
        add(0, 24'h01_0005, 8'h00, 2, "R1");  // empty after reset: miss
        add(0, 24'h01_0005, 8'h00, 0, "R3");  // hit
        add(0, 24'h05_0A0B, 8'h00, 4, "R4");  // miss with long wait
        add(0, 24'h02_0005, 8'h00, 0, "R6");  // same index, other bank
        add(0, 24'h01_0005, 8'h00, 1, "R6");  // evicted: miss
        add(0, 24'h01_0045, 8'h00, 3, "R6");  // same index, other upper bits
        add(0, 24'h01_0045, 8'h00, 0, "R5");  // fill then hit
        add(1, 24'h01_0045, 8'h5A, 1, "R8");  // write hit
        add(0, 24'h01_0045, 8'h00, 0, "R8");  // hit returns written byte
        add(1, 24'h03_1234, 8'h77, 0, "R8");  // write miss
        add(0, 24'h03_1234, 8'h00, 2, "R8");  // no allocate: miss
        add(0, 24'h03_1234, 8'h00, 0, "R5");  // hit
        add(0, 24'hEF_0010, 8'h00, 1, "R7");  // reserved bank miss
        add(0, 24'hEF_0010, 8'h00, 0, "R7");  // still miss
        add(2, 24'h03_1234, 8'h00, 0, "R9");  // flush with qualifier high
        add(0, 24'h03_1234, 8'h00, 1, "R9");  // miss after flush
        add(0, 24'h03_1234, 8'h00, 0, "R3");  // hit again
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        while (ops.size() > 0 || mst != S_IDLE) @(posedge clk);
        repeat (8) @(posedge clk);
        @(negedge clk);
        finished = 1'b1;
        check("R9", 64'(flcycles), 64'(DEPTH));
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        finished = 1'b1;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

endmodule